// File: doc/BRIEF.md
# JTAG Debug Port with Bus Memory Access

This block is a JTAG test access port with three extra instructions. An external debugger uses them to read and write any word on an on-chip Wishbone classic bus. The JTAG side runs on TCK with an asynchronous active-low TRST. The bus side is a single-master Wishbone classic port on the system clock. A toggle handshake links the two domains, with a two-flop synchronizer in each direction.

The debugger first shifts a word address into a 29-bit address register. It then streams 64-bit words through a data register. Every completed data shift performs one bus access and advances the address by one. No address reload is needed between words.

The block fetches the read data ahead of time:

- Any Update-DR that sets or advances the address launches a read of the next word.
- Capture-DR loads the word that was fetched ahead of the shift.
- Under the read-write instruction, the same Update-DR first writes the shifted-in word.

An IDCODE register and a one-bit BYPASS register complete the test access port.

Top module: `jtag_wb_bridge`

## Requirements
- R1: Test-Logic-Reset selects the IDCODE instruction, whether it is reached by TRST low or by five TCK rising edges with TMS high. The IDCODE register shifts out the 32-bit parameter `IDCODE_VAL`, least significant bit first.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001. The codes are: 4'b0001 IDCODE, 4'b0101 address, 4'b0110 read, 4'b0111 read-write. Every other code, including 4'b1111, selects BYPASS.
- R3: BYPASS is a single stage that captures 0, so TDO repeats TDI one TCK later.
- R4: Under the address instruction, the 29-bit word address shifts out its value from before the load. It takes the shifted-in value at Update-DR and changes at no other time.
- R5: Under the read-write instruction, a 64-bit shift returns the earlier content of the addressed word. At Update-DR the shifted-in word is written there.
- R6: Under the read instruction, the addressed word shifts out and the shifted-in bits have no effect: the bus sees no write.
- R7: Each data Update-DR advances the address by one, wrapping from 2^29-1 to 0. The next data shift therefore reaches the following word.
- R8: On the bus, STB is only high with CYC, and the byte select is all ones. Address, write enable and write data stay unchanged from STB rising until ACK.
- R9: TDO changes only on the falling edge of TCK. TDO_OE is high exactly during Shift-IR and Shift-DR.
- R10: At most one bus request is outstanding. An address load costs one bus read; a read-write shift costs one write followed by one read; a read shift costs one read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on TCK falling edge |
| tdo_oe | output | 1 | TDO driver enable during shift states |
| clk | input | 1 | System clock |
| rst | input | 1 | System reset, synchronous, active high |
| wb_adr_o | output | ADDR_W | Word address |
| wb_dat_o | output | DATA_W | Write data |
| wb_dat_i | input | DATA_W | Read data |
| wb_sel_o | output | DATA_W/8 | Byte select, all ones |
| wb_we_o | output | 1 | Write enable |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The handshake checks assume the debugger spends enough TCK cycles in Run-Test/Idle after each Update-DR that launches a bus request. The bus round trip and the synchronizers must finish before the next Update-DR or data Capture-DR. The bench idles eight TCK cycles after each such update, with TCK ten times slower than the system clock. The bus-hold checks assume the slave always acknowledges in the end. The bench slave answers after zero to two wait cycles, varying from one access to the next.

// File: rtl/jwb_pkg.sv
package jwb_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_ADDR    = 4'b0101;
  localparam logic [IR_W-1:0] OP_READ    = 4'b0110;
  localparam logic [IR_W-1:0] OP_RW      = 4'b0111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      TLR:     n = tms ? TLR    : RTI;
      RTI:     n = tms ? SEL_DR : RTI;
      SEL_DR:  n = tms ? SEL_IR : CAP_DR;
      CAP_DR:  n = tms ? EX1_DR : SH_DR;
      SH_DR:   n = tms ? EX1_DR : SH_DR;
      EX1_DR:  n = tms ? UPD_DR : PA_DR;
      PA_DR:   n = tms ? EX2_DR : PA_DR;
      EX2_DR:  n = tms ? UPD_DR : SH_DR;
      UPD_DR:  n = tms ? SEL_DR : RTI;
      SEL_IR:  n = tms ? TLR    : CAP_IR;
      CAP_IR:  n = tms ? EX1_IR : SH_IR;
      SH_IR:   n = tms ? EX1_IR : SH_IR;
      EX1_IR:  n = tms ? UPD_IR : PA_IR;
      PA_IR:   n = tms ? EX2_IR : PA_IR;
      EX2_IR:  n = tms ? UPD_IR : SH_IR;
      UPD_IR:  n = tms ? SEL_DR : RTI;
      default: n = TLR;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/jwb_sync.sv
module jwb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jwb_tap_ctrl.sv
module jwb_tap_ctrl
  import jwb_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_o
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_o <= TLR;
    else         state_o <= tap_next(state_o, tms);
  end

  // R1
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
    |-> (state_o == TLR));
endmodule

// File: rtl/jwb_bus_master.sv
module jwb_bus_master #(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl_i,
  input  logic              rq_we_i,
  input  logic [ADDR_W-1:0] rq_waddr_i,
  input  logic [ADDR_W-1:0] rq_raddr_i,
  input  logic [DATA_W-1:0] rq_wdata_i,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W/8-1:0] wb_sel_o,
  output logic              wb_we_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  input  logic              wb_ack_i
);
  typedef enum logic [1:0] {BM_IDLE, BM_WRITE, BM_READ} bm_state_e;

  bm_state_e bm;
  logic      req_s, req_seen;
  logic      rst_n;

  assign rst_n    = ~rst;
  assign wb_sel_o = '1;

  jwb_sync #(.STAGES(2)) u_req_sync (
    .clk(clk), .arst_n(rst_n), .d(req_tgl_i), .q(req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bm <= BM_IDLE; req_seen <= 1'b0; ack_tgl_o <= 1'b0; rdata_o <= '0;
      wb_adr_o <= '0; wb_dat_o <= '0; wb_we_o <= 1'b0; wb_cyc_o <= 1'b0; wb_stb_o <= 1'b0;
    end else begin
      case (bm)
        BM_IDLE: if (req_s != req_seen) begin
          req_seen <= req_s;
          wb_cyc_o <= 1'b1;
          wb_stb_o <= 1'b1;
          if (rq_we_i) begin
            bm <= BM_WRITE; wb_adr_o <= rq_waddr_i; wb_dat_o <= rq_wdata_i; wb_we_o <= 1'b1;
          end else begin
            bm <= BM_READ; wb_adr_o <= rq_raddr_i; wb_we_o <= 1'b0;
          end
        end
        BM_WRITE: if (wb_ack_i) begin
          bm <= BM_READ; wb_adr_o <= rq_raddr_i; wb_we_o <= 1'b0;
        end
        BM_READ: if (wb_ack_i) begin
          bm <= BM_IDLE; wb_cyc_o <= 1'b0; wb_stb_o <= 1'b0;
          rdata_o <= wb_dat_i; ack_tgl_o <= ~ack_tgl_o;
        end
        default: bm <= BM_IDLE;
      endcase
    end
  end

  // R8
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> (wb_cyc_o && (wb_sel_o == '1)));
  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (bm != BM_IDLE) |-> (req_s == req_seen));
endmodule

// File: rtl/jtag_wb_bridge.sv
module jtag_wb_bridge
  import jwb_pkg::*;
#(
  parameter int          ADDR_W     = 29,
  parameter int          DATA_W     = 64,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5B_C0DF
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdo_oe,
  input  logic                clk,
  input  logic                rst,
  output logic [ADDR_W-1:0]   wb_adr_o,
  output logic [DATA_W-1:0]   wb_dat_o,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W/8-1:0] wb_sel_o,
  output logic                wb_we_o,
  output logic                wb_cyc_o,
  output logic                wb_stb_o,
  input  logic                wb_ack_i
);
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  tap_state_e        st;
  logic [IR_W-1:0]   ir, ir_sr;
  logic [ADDR_W-1:0] mar, adr_sr, rq_waddr, rq_raddr;
  logic [DATA_W-1:0] dat_sr, rd_q, rq_wdata, bus_rdata;
  logic [31:0]       id_sr;
  logic              byp_sr, rq_we, req_tgl, ack_tgl, ack_s, ack_seen, dr_lsb;

  jwb_tap_ctrl u_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .state_o(st));

  // Named events for logic and assertions
  wire in_tlr    = (st == TLR);
  wire cap_dr_ev = (st == CAP_DR);
  wire sh_dr_ev  = (st == SH_DR);
  wire upd_dr_ev = (st == UPD_DR);
  wire cap_ir_ev = (st == CAP_IR);
  wire sh_ir_ev  = (st == SH_IR);
  wire upd_ir_ev = (st == UPD_IR);
  wire sel_addr  = (ir == OP_ADDR);
  wire sel_data  = (ir == OP_READ) || (ir == OP_RW);
  wire sel_id    = (ir == OP_IDCODE);
  wire launch_ev = upd_dr_ev && (sel_addr || sel_data);
  wire busy      = (req_tgl != ack_seen);
  wire done_ev   = (ack_s != ack_seen);

  // Instruction register
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir <= OP_IDCODE; ir_sr <= '0;
    end else begin
      if (in_tlr)         ir <= OP_IDCODE;
      else if (upd_ir_ev) ir <= ir_sr;
      if (cap_ir_ev)      ir_sr <= IR_CAPTURE;
      else if (sh_ir_ev)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  // Data register shift stages
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      adr_sr <= '0; dat_sr <= '0; id_sr <= '0; byp_sr <= 1'b0;
    end else if (cap_dr_ev) begin
      adr_sr <= mar; dat_sr <= rd_q; id_sr <= IDCODE_VAL; byp_sr <= 1'b0;
    end else if (sh_dr_ev) begin
      if (sel_addr) adr_sr <= {tdi, adr_sr[ADDR_W-1:1]};
      if (sel_data) dat_sr <= {tdi, dat_sr[DATA_W-1:1]};
      if (sel_id)   id_sr  <= {tdi, id_sr[31:1]};
      byp_sr <= tdi;
    end
  end

  // Address, request launch and completion
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      mar <= '0; rq_we <= 1'b0; rq_waddr <= '0; rq_raddr <= '0; rq_wdata <= '0;
      req_tgl <= 1'b0; ack_seen <= 1'b0; rd_q <= '0;
    end else begin
      if (upd_dr_ev && sel_addr) begin
        mar <= adr_sr; rq_we <= 1'b0; rq_raddr <= adr_sr; req_tgl <= ~req_tgl;
      end else if (upd_dr_ev && sel_data) begin
        mar      <= addr_step(mar);
        rq_we    <= (ir == OP_RW);
        rq_waddr <= mar;
        rq_wdata <= dat_sr;
        rq_raddr <= addr_step(mar);
        req_tgl  <= ~req_tgl;
      end
      if (done_ev) begin
        ack_seen <= ack_s; rd_q <= bus_rdata;
      end
    end
  end

  always_comb begin
    if (sel_addr)      dr_lsb = adr_sr[0];
    else if (sel_data) dr_lsb = dat_sr[0];
    else if (sel_id)   dr_lsb = id_sr[0];
    else               dr_lsb = byp_sr;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo <= 1'b0; tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir_ev || sh_dr_ev;
      tdo    <= sh_ir_ev ? ir_sr[0] : dr_lsb;
    end
  end

  jwb_sync #(.STAGES(2)) u_ack_sync (.clk(tck), .arst_n(trst_n), .d(ack_tgl), .q(ack_s));

  jwb_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .req_tgl_i(req_tgl), .rq_we_i(rq_we),
    .rq_waddr_i(rq_waddr), .rq_raddr_i(rq_raddr), .rq_wdata_i(rq_wdata),
    .ack_tgl_o(ack_tgl), .rdata_o(bus_rdata),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_sel_o(wb_sel_o),
    .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i)
  );

  // R10
  launch_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    launch_ev |-> !busy);
  // R10
  capture_ready_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_ev && sel_data) |-> !busy);
  // R1
  tlr_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
    in_tlr |=> (ir == OP_IDCODE));
  // R4
  mar_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_dr_ev |=> $stable(mar));
endmodule

// File: tb/jtag_wb_bridge_tb_top.sv
module jtag_wb_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_HALF   = 5 * CLK_PERIOD;
  localparam logic [31:0] IDV = 32'h1A5B_C0DF;

  logic clk = 0, rst = 1, tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic tdo, tdo_oe;
  logic [28:0] wb_adr;
  logic [63:0] wb_dat_o, wb_dat_i;
  logic [7:0]  wb_sel;
  logic wb_we, wb_cyc, wb_stb, wb_ack;

  int n_tests = 0, n_fail = 0;
  int rise_chg = 0, oe_bad = 0;
  int proto_err = 0, n_acks = 0, n_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_wb_bridge dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .clk(clk), .rst(rst), .wb_adr_o(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_sel_o(wb_sel), .wb_we_o(wb_we), .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_ack_i(wb_ack)
  );

  function automatic logic [63:0] init_word(input int k);
    return 64'h1111_1111_1111_1111 * 64'(k + 1);
  endfunction

  // Bus slave: 16 words, 0..2 wait cycles
  logic [63:0] mem [16];
  logic [1:0]  wcnt, pick;
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      wb_ack <= 1'b0; wcnt <= '0; pick <= '0; wb_dat_i <= '0;
    end else if (wb_cyc && wb_stb && !wb_ack) begin
      if (wcnt == 0) begin
        wb_ack   <= 1'b1;
        wb_dat_i <= mem[wb_adr[3:0]];
        if (wb_we) mem[wb_adr[3:0]] <= wb_dat_o;
        pick <= (pick == 2) ? 2'd0 : pick + 2'd1;
        wcnt <= pick;
      end else wcnt <= wcnt - 2'd1;
    end else wb_ack <= 1'b0;
  end

  // Bus protocol monitor
  logic p_stb, p_ack, p_we;
  logic [28:0] p_adr;
  logic [63:0] p_dat;
  always_ff @(posedge clk) begin
    p_stb <= wb_stb; p_ack <= wb_ack; p_we <= wb_we; p_adr <= wb_adr; p_dat <= wb_dat_o;
    if (!rst) begin
      if (wb_stb && (!wb_cyc || wb_sel != 8'hFF)) proto_err <= proto_err + 1;
      if (p_stb && !p_ack && (!wb_stb || wb_adr != p_adr || wb_we != p_we || wb_dat_o != p_dat))
        proto_err <= proto_err + 1;
      if (wb_stb && wb_ack) begin
        n_acks <= n_acks + 1;
        if (wb_we) n_wr <= n_wr + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic tck_cycle(input logic ms, input logic di, output logic pre, output logic post);
    tms = ms; tdi = di;
    #(TCK_HALF); pre = tdo;
    tck = 1; #1; post = tdo;
    #(TCK_HALF - 1); tck = 0;
  endtask

  task automatic idle(input int n);
    logic a, b;
    for (int i = 0; i < n; i++) tck_cycle(1'b0, 1'b0, a, b);
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
    logic a, b;
    tck_cycle(1, 0, a, b); tck_cycle(1, 0, a, b);
    tck_cycle(0, 0, a, b); tck_cycle(0, 0, a, b);
    for (int i = 0; i < 4; i++) begin
      tck_cycle(i == 3, code[i], a, b);
      cap[i] = a;
      if (a !== b) rise_chg++;
      if (tdo_oe !== 1'b1) oe_bad++;
    end
    tck_cycle(1, 0, a, b); tck_cycle(0, 0, a, b);
    idle(2);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic a, b;
    dout = '0;
    tck_cycle(1, 0, a, b); tck_cycle(0, 0, a, b); tck_cycle(0, 0, a, b);
    for (int i = 0; i < n; i++) begin
      tck_cycle(i == n - 1, din[i], a, b);
      dout[i] = a;
      if (a !== b) rise_chg++;
      if (tdo_oe !== 1'b1) oe_bad++;
    end
    tck_cycle(1, 0, a, b); tck_cycle(0, 0, a, b);
    idle(8);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R9 tdo_oe after reset", {63'd0, tdo_oe}, 64'd0);
    check("R8 no bus cycle at reset", {63'd0, wb_cyc}, 64'd0);
    idle(1);
    shift_dr(32, 64'd0, d);
    check("R1 IDCODE after TRST", d, {32'd0, IDV});
    check("R9 tdo_oe low in idle", {63'd0, tdo_oe}, 64'd0);
  endtask

  task automatic t_bypass;
    logic [3:0] c;
    logic [63:0] d;
    load_ir(4'b1111, c);
    check("R2 IR capture pattern", {60'd0, c}, 64'd1);
    shift_dr(8, 64'hB5, d);
    check("R3 bypass delay", d, {56'd0, 8'hB5 << 1} & 64'hFF);
    load_ir(4'b1010, c);
    shift_dr(8, 64'h6C, d);
    check("R2 unused code acts as bypass", d, 64'hD8);
  endtask

  task automatic t_tms_reset;
    logic [3:0] c;
    logic [63:0] d;
    load_ir(4'b0101, c);
    idle(1);
    for (int i = 0; i < 5; i++) begin
      logic a, b;
      tck_cycle(1, 0, a, b);
    end
    idle(1);
    shift_dr(32, 64'd0, d);
    check("R1 IDCODE after five TMS high", d, {32'd0, IDV});
  endtask

  task automatic t_addr;
    logic [3:0] c;
    logic [63:0] d;
    int a0;
    load_ir(4'b0101, c);
    a0 = n_acks;
    shift_dr(29, 64'd1, d);
    check("R4 old address out (reset value)", d, 64'd0);
    check("R10 address load costs one read", 64'(n_acks - a0), 64'd1);
    shift_dr(29, 64'd5, d);
    check("R4 old address out", d, 64'd1);
    shift_dr(29, 64'd1, d);
    check("R4 old address out again", d, 64'd5);
  endtask

  task automatic t_rw;
    logic [3:0] c;
    logic [63:0] d;
    int a0, w0;
    load_ir(4'b0111, c);
    a0 = n_acks; w0 = n_wr;
    shift_dr(64, 64'h5555_5555_5555_5555, d);
    check("R5 old word 1 out", d, init_word(1));
    check("R10 read-write costs two accesses", 64'(n_acks - a0), 64'd2);
    check("R10 read-write costs one write", 64'(n_wr - w0), 64'd1);
    shift_dr(64, 64'hAAAA_AAAA_AAAA_AAAA, d);
    check("R7 streamed to word 2", d, init_word(2));
    check("R5 word 1 written", mem[1], 64'h5555_5555_5555_5555);
    load_ir(4'b0101, c);
    shift_dr(29, 64'd1, d);
    check("R7 address advanced twice", d, 64'd3);
    load_ir(4'b0111, c);
    shift_dr(64, 64'h0123_4567_89AB_CDEF, d);
    check("R5 previous write returned", d, 64'h5555_5555_5555_5555);
    check("R5 word 1 overwritten", mem[1], 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_read;
    logic [3:0] c;
    logic [63:0] d;
    int a0, w0;
    load_ir(4'b0110, c);
    a0 = n_acks; w0 = n_wr;
    shift_dr(64, '1, d);
    check("R6 read word 2", d, 64'hAAAA_AAAA_AAAA_AAAA);
    check("R6 no write under read", 64'(n_wr - w0), 64'd0);
    check("R10 read costs one access", 64'(n_acks - a0), 64'd1);
    check("R6 word 2 unchanged", mem[2], 64'hAAAA_AAAA_AAAA_AAAA);
    shift_dr(64, '1, d);
    check("R7 read streamed to word 3", d, init_word(3));
    check("R6 word 3 unchanged", mem[3], init_word(3));
  endtask

  task automatic t_wrap;
    logic [3:0] c;
    logic [63:0] d;
    load_ir(4'b0101, c);
    shift_dr(29, 64'h1FFF_FFFF, d);
    check("R7 address after two reads", d, 64'd4);
    load_ir(4'b0111, c);
    shift_dr(64, 64'hFEED_FACE_0BAD_CAFE, d);
    check("R5 top word old content", d, init_word(15));
    check("R5 top word written", mem[15], 64'hFEED_FACE_0BAD_CAFE);
    load_ir(4'b0101, c);
    shift_dr(29, 64'd0, d);
    check("R7 address wraps to 0", d, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20 * 1000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (6) @(posedge clk);
    #1 rst = 0; trst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_bypass();
    t_tms_reset();
    t_addr();
    t_rw();
    t_read();
    t_wrap();
    check("R8 bus protocol errors", 64'(proto_err), 64'd0);
    check("R9 TDO changed on rising edge", 64'(rise_chg), 64'd0);
    check("R9 tdo_oe low while shifting", 64'(oe_bad), 64'd0);
    summary();
    $finish;
  end
endmodule